// File: doc/BRIEF.md
# Programmable Asynchronous Character Receiver

This block recovers characters from an asynchronous serial line. A separate divider supplies a one-cycle enable pulse at sixteen times the bit rate, and the receiver samples the line only on those pulses. It searches for a start bit and confirms it at mid-bit. It then shifts in the data bits, least significant first, optionally checks a parity bit and samples the stop bit. The finished character is copied into a holding register that a processor reads.

Software chooses the frame through configuration inputs: a word length of 5 to 8 bits, no parity or even or odd parity, and one stop bit or a longer stop period. The receiver takes a copy of the configuration when it detects a start edge, so a change in the middle of a frame does not disturb that frame. The holding register carries a full flag and three error flags. A single-cycle read strobe tells the block that the processor has taken the character.

Top module: `serial_char_rx`

## Requirements
- R1: On a tick where the line is low in the idle state, the receiver treats that tick as a candidate start. The start is kept only if the line is still low on the 8th tick after it. Otherwise the receiver returns to idle, and no character and no flag change results.
- R2: Data bits are taken 16 ticks apart, starting 16 ticks after the start sample. The first bit received goes to rx_data bit 0. Holding-register bits above the word length read 0.
- R3: cfg_len selects the word length: 2'b00 gives 8 bits, 2'b01 gives 7, 2'b10 gives 6 and 2'b11 gives 5.
- R4: When cfg_par_en is 1, one parity bit follows the data. With cfg_par_odd 0 the data ones plus the parity bit must be even, and with cfg_par_odd 1 they must be odd. A mismatch sets err_parity with the character. The parity bit never enters rx_data. When cfg_par_en is 0, err_parity loads 0.
- R5: With cfg_stop_sel 0 the frame has one stop bit. With cfg_stop_sel 1 it has 1.5 stop bits for a 5-bit word without parity, 1 stop bit for an 8-bit word with parity, and 2 stop bits otherwise. err_frame loads 1 when the first stop-bit sample is low.
- R6: A character completes on a fixed tick counted from the start of the stop bit (index 0). With one stop bit it completes on tick index 8, with 1.5 stop bits on index 20, and with 2 stop bits on index 24. rx_full rises at the second rising clock edge counting the edge that samples the completing tick.
- R7: If a character completes while rx_full is 0, or in the same cycle as rd_strobe, the block loads rx_data, err_parity and err_frame and sets rx_full.
- R8: rd_strobe clears rx_full and err_overrun.
- R9: If a character completes while rx_full is 1 and rd_strobe is 0, the block sets err_overrun and drops the character. rx_data, err_parity and err_frame keep their old values.
- R10: The receiver state advances only on clock edges where tick_16x is 1. Reset (rst high, synchronous) clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Sampling enable, sixteen per bit period |
| rxd | input | 1 | Serial line, idle high, synchronous to clk |
| cfg_len | input | 2 | Word length code (R3) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop_sel | input | 1 | Longer stop period select (R5) |
| rd_strobe | input | 1 | Processor has read the holding register |
| rx_data | output | 8 | Holding register |
| rx_full | output | 1 | Holding register holds an unread character |
| err_parity | output | 1 | Parity error of the held character |
| err_frame | output | 1 | Framing error of the held character |
| err_overrun | output | 1 | A character was dropped because the register was full |

## Verification
Every character result appears two clock edges after the tick that completes it. The frame engine registers the completed character on the tick edge, and the holding stage takes it on the next edge. A read strobe clears the flags one edge after it is sampled. The bench drives one tick every four clock cycles and checks only after a tick or strobe task has run out its remaining cycles, so the result is settled at every check. The stop-period test counts ticks from the start of the stop bit. It checks that rx_full is still low one tick before the tick at which it is due, and high right after that tick.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        LEN_8 = 2'b00,
        LEN_7 = 2'b01,
        LEN_6 = 2'b10,
        LEN_5 = 2'b11
    } len_e;

    typedef enum logic [1:0] {
        STOP_ONE  = 2'd0,
        STOP_HALF = 2'd1,
        STOP_TWO  = 2'd2
    } stop_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4,
        S_EXTRA = 3'd5
    } state_e;

    typedef struct packed {
        len_e len;
        logic par_en;
        logic par_odd;
        logic stop_sel;
    } cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } char_t;

    // number of data bits for a length code: 8 minus the code
    function automatic logic [3:0] word_bits(len_e l);
        return 4'd8 - {2'b00, l};
    endfunction

    // length of the stop period implied by the configuration
    function automatic stop_e stop_kind(cfg_t c);
        if (!c.stop_sel)                    return STOP_ONE;
        else if (c.len == LEN_5 && !c.par_en) return STOP_HALF;
        else if (c.len == LEN_8 && c.par_en)  return STOP_ONE;
        else                                return STOP_TWO;
    endfunction

endpackage

// File: rtl/rxs_frame.sv
module rxs_frame
    import rxs_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  rxd,
    input  cfg_t  cfg_in,
    output logic  out_valid,
    output char_t out_char
);
    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] MID      = CW'(TICKS / 2 - 1);
    localparam logic [CW-1:0] LAST     = CW'(TICKS - 1);
    localparam logic [CW-1:0] HALF_END = CW'((TICKS * 3) / 4 - 1);

    state_e            state;
    logic [CW-1:0]     cnt;
    logic [2:0]        bit_idx;
    cfg_t              cfg_q;
    logic [DATA_W-1:0] sr;
    logic              par_acc;
    logic              perr_q;
    logic              ferr_q;

    stop_e         kind;
    logic [3:0]    nbits;
    logic [CW-1:0] extra_end;
    logic          last_bit;

    assign kind      = stop_kind(cfg_q);
    assign nbits     = word_bits(cfg_q.len);
    assign extra_end = (kind == STOP_HALF) ? HALF_END : LAST;
    assign last_bit  = ({1'b0, bit_idx} == (nbits - 4'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            cfg_q     <= '0;
            sr        <= '0;
            par_acc   <= 1'b0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (tick) begin
                unique case (state)
                    S_IDLE: begin
                        if (!rxd) begin
                            state <= S_START;
                            cnt   <= '0;
                            cfg_q <= cfg_in;
                        end
                    end
                    S_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rxd) begin
                                state   <= S_DATA;
                                sr      <= '0;
                                bit_idx <= '0;
                                par_acc <= 1'b0;
                                perr_q  <= 1'b0;
                                ferr_q  <= 1'b0;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    S_DATA: begin
                        if (cnt == LAST) begin
                            cnt         <= '0;
                            sr[bit_idx] <= rxd;
                            par_acc     <= par_acc ^ rxd;
                            bit_idx     <= bit_idx + 3'd1;
                            if (last_bit)
                                state <= cfg_q.par_en ? S_PAR : S_STOP;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    S_PAR: begin
                        if (cnt == LAST) begin
                            cnt    <= '0;
                            perr_q <= ((par_acc ^ rxd) != cfg_q.par_odd);
                            state  <= S_STOP;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    S_STOP: begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            if (kind == STOP_ONE) begin
                                out_valid <= 1'b1;
                                out_char  <= '{data: sr, perr: perr_q, ferr: !rxd};
                                state     <= S_IDLE;
                            end else begin
                                ferr_q <= !rxd;
                                state  <= S_EXTRA;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    S_EXTRA: begin
                        if (cnt == extra_end) begin
                            cnt       <= '0;
                            out_valid <= 1'b1;
                            out_char  <= '{data: sr, perr: perr_q, ferr: ferr_q};
                            state     <= S_IDLE;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxs_hold.sv
module rxs_hold
    import rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  char_t             in_char,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              perr,
    output logic              ferr,
    output logic              ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            perr <= 1'b0;
            ferr <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
            end
            if (in_valid) begin
                if (full && !rd) begin
                    ovr <= 1'b1;
                end else begin
                    data <= in_char.data;
                    perr <= in_char.perr;
                    ferr <= in_char.ferr;
                    full <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
    import rxs_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_16x,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop_sel,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun
);
    cfg_t  cfg_now;
    logic  frame_valid;
    char_t frame_char;

    assign cfg_now = '{len: len_e'(cfg_len), par_en: cfg_par_en,
                       par_odd: cfg_par_odd, stop_sel: cfg_stop_sel};

    rxs_frame #(.TICKS(TICKS)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_16x),
        .rxd      (rxd),
        .cfg_in   (cfg_now),
        .out_valid(frame_valid),
        .out_char (frame_char)
    );

    rxs_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .in_valid(frame_valid),
        .in_char (frame_char),
        .rd      (rd_strobe),
        .data    (rx_data),
        .full    (rx_full),
        .perr    (err_parity),
        .ferr    (err_frame),
        .ovr     (err_overrun)
    );

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
    import rxs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       valid,
    input char_t      vchar,
    input logic       rd,
    input logic       full,
    input logic       ovr,
    input logic [7:0] data
);
    // R10: a completed character only follows a sampling tick
    a_r10_valid_after_tick: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(tick));

    // R7: an accepted character lands in the holding register
    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        valid && (!full || rd) |=> full && (data == $past(vchar.data)));

    // R9: a character arriving on a full register is dropped
    a_r9_overrun_drop: assert property (@(posedge clk) disable iff (rst)
        valid && full && !rd |=> ovr && $stable(data));

    // R9: overrun can only be pending while a character is held
    a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (rst)
        ovr |-> full);

    // R8: a read with no arrival empties the register
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd && !valid |=> !full && !ovr);

    // R6: full only rises on the edge after a completed character
    a_r6_full_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(valid));

endmodule

bind serial_char_rx rxs_checker u_chk (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_16x),
    .valid(frame_valid),
    .vchar(frame_char),
    .rd   (rd_strobe),
    .full (rx_full),
    .ovr  (err_overrun),
    .data (rx_data)
);

// File: tb/serial_char_rx_test.sv
module serial_char_rx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'b00;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop_sel = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, err_parity, err_frame, err_overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_char_rx uut (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop_sel(cfg_stop_sel), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [1:0] len);
        return 8 - int'(len);
    endfunction

    function automatic logic [7:0] mask_of(input int n);
        return 8'((9'd1 << n) - 9'd1);
    endfunction

    // tick index (from start of stop bit) at which the character completes
    function automatic int done_idx(input logic [1:0] len, input logic pe, input logic ss);
        if (!ss) return 8;
        if (len == 2'b11 && !pe) return 20;
        if (len == 2'b00 && pe) return 8;
        return 24;
    endfunction

    task automatic tick_once();
        @(negedge clk) tick_16x = 1'b1;
        @(negedge clk) tick_16x = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic pe, input logic po, input logic ss);
        cfg_len = len; cfg_par_en = pe; cfg_par_odd = po; cfg_stop_sel = ss;
    endtask

    // start, data and parity windows; leaves the line at the start of the stop bit
    task automatic send_head(input logic [7:0] d, input logic bad_par);
        int n = nbits_of(cfg_len);
        logic p = ^(d & mask_of(n)) ^ cfg_par_odd ^ bad_par;
        rxd = 1'b0; ticks(16);
        for (int i = 0; i < n; i++) begin rxd = d[i]; ticks(16); end
        if (cfg_par_en) begin rxd = p; ticks(16); end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        send_head(d, bad_par);
        rxd = !bad_stop; ticks(16);
        rxd = 1'b1; ticks(24);
    endtask

    logic [7:0] m_data;
    logic       m_full, m_perr, m_ferr, m_ovr;

    task automatic model_arrive(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        if (m_full) m_ovr = 1'b1;
        else begin
            m_data = d & mask_of(nbits_of(cfg_len));
            m_perr = cfg_par_en & bad_par;
            m_ferr = bad_stop;
            m_full = 1'b1;
        end
    endtask

    task automatic check_model(input string tag);
        chk({tag, " data"}, 32'(rx_data), 32'(m_data));
        chk({tag, " full"}, 32'(rx_full), 32'(m_full));
        chk({tag, " perr"}, 32'(err_parity), 32'(m_perr));
        chk({tag, " ferr"}, 32'(err_frame), 32'(m_ferr));
        chk({tag, " ovr"}, 32'(err_overrun), 32'(m_ovr));
    endtask

    task automatic read_model();
        do_read();
        m_full = 1'b0; m_ovr = 1'b0;
        chk("R8 read clears full", 32'(rx_full), 32'd0);
        chk("R8 read clears overrun", 32'(err_overrun), 32'd0);
    endtask

    // exact completion tick for the configured stop period
    task automatic timed_frame(input string tag, input logic [7:0] d);
        int k = done_idx(cfg_len, cfg_par_en, cfg_stop_sel);
        send_head(d, 1'b0);
        rxd = 1'b1;
        ticks(k);
        chk({tag, " not yet full"}, 32'(rx_full), 32'd0);
        tick_once();
        chk({tag, " full on time"}, 32'(rx_full), 32'd1);
        ticks(32 - k);
        model_arrive(d, 1'b0, 1'b0);
        check_model(tag);
        read_model();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_data = '0; m_full = 0; m_perr = 0; m_ferr = 0; m_ovr = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_model("R10 reset state");

        // R10: line low without ticks does nothing
        rxd = 1'b0;
        repeat (40) @(negedge clk);
        rxd = 1'b1;
        ticks(40);
        chk("R10 no tick no start", 32'(rx_full), 32'd0);

        // R2 R3: 8-bit, no parity
        set_cfg(2'b00, 0, 0, 0);
        send_frame(8'hA5, 0, 0); model_arrive(8'hA5, 0, 0);
        check_model("R2 8N1 A5"); read_model();

        // R2 R3: 5-bit word, upper bits zero
        set_cfg(2'b11, 0, 0, 0);
        send_frame(8'hFF, 0, 0); model_arrive(8'hFF, 0, 0);
        check_model("R3 5-bit upper zero"); read_model();

        // R4: even parity good, even bad, odd good, odd bad
        set_cfg(2'b01, 1, 0, 0);
        send_frame(8'h35, 0, 0); model_arrive(8'h35, 0, 0);
        check_model("R4 even good"); read_model();
        send_frame(8'h35, 1, 0); model_arrive(8'h35, 1, 0);
        check_model("R4 even bad"); read_model();
        set_cfg(2'b00, 1, 1, 0);
        send_frame(8'hC3, 0, 0); model_arrive(8'hC3, 0, 0);
        check_model("R4 odd good"); read_model();
        send_frame(8'hC3, 1, 0); model_arrive(8'hC3, 1, 0);
        check_model("R4 odd bad"); read_model();

        // R5: framing error
        set_cfg(2'b10, 0, 0, 0);
        send_frame(8'h2A, 0, 1); model_arrive(8'h2A, 0, 1);
        check_model("R5 framing error"); read_model();

        // R5 R6: completion tick of each stop period
        set_cfg(2'b00, 0, 0, 0); timed_frame("R6 one stop", 8'h5A);
        set_cfg(2'b11, 0, 0, 1); timed_frame("R5 R6 one and a half stop", 8'h13);
        set_cfg(2'b01, 1, 0, 1); timed_frame("R5 R6 two stop", 8'h66);
        set_cfg(2'b00, 1, 1, 1); timed_frame("R5 R6 8-bit parity one stop", 8'h81);

        // R1: start low for only 8 ticks is rejected
        set_cfg(2'b00, 0, 0, 0);
        send_frame(8'h3C, 0, 0); model_arrive(8'h3C, 0, 0);
        rxd = 1'b0; ticks(8); rxd = 1'b1; ticks(40);
        check_model("R1 short start rejected");
        read_model();

        // R9 R7: overrun keeps old data, read then clears
        send_frame(8'h11, 0, 0); model_arrive(8'h11, 0, 0);
        send_frame(8'h22, 1, 1); model_arrive(8'h22, 1, 1);
        check_model("R9 overrun keeps old");
        read_model();
        send_frame(8'h44, 0, 0); model_arrive(8'h44, 0, 0);
        check_model("R7 load after read"); read_model();

        // random frames, occasional skipped reads
        for (int i = 0; i < 50; i++) begin
            logic [7:0] d;
            logic bp, bs;
            set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            d  = 8'($urandom);
            bp = ($urandom % 5) == 0;
            bs = ($urandom % 7) == 0;
            send_frame(d, bp, bs);
            model_arrive(d, bp, bs);
            check_model("R2 R4 R5 R7 R9 random");
            if (($urandom % 4) != 0) read_model();
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule